// File: doc/BRIEF.md
# 8-bit ALU with Flag Register

The block is the arithmetic and logic unit of a small 8-bit datapath. It takes two 8-bit operands and a 3-bit operation code and produces an 8-bit result in the same cycle, combinationally. It also keeps a registered 8-bit status byte that records five conditions about that result: carry or borrow, half carry between the two hex digits, sign, even parity and zero. The status byte changes only on the clock edge where the operation strobe is high.

Add-with-carry and subtract-with-borrow take their incoming carry from the stored carry flag. The compare operation updates the flags exactly as a subtract would, but it does not raise the result-write qualifier. A full-byte load port writes the status byte directly, which lets surrounding logic save and restore it. The three unused bit positions always read as fixed constants.

Top module: `alu8_flags`

## Requirements
- R1: After reset (`rst_n` low), `flags` reads 8'h02. Bit 1 is set and every other bit is clear.
- R2: `result` is combinational from the inputs. The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR and 7 compare. Codes 1 and 3 use the stored carry flag (`flags[0]`) as the carry-in or borrow-in. Code 0 and code 2 ignore it.
- R3: `flags[0]` (carry) takes the carry out of bit 7 for the add codes. For codes 2, 3 and 7 it is a borrow: it is 1 when the unsigned minuend is smaller than the subtrahend plus the borrow-in.
- R4: `flags[4]` (half carry) takes the carry from bit 3 into bit 4 for the add codes. For the subtract and compare codes it takes the matching half borrow. AND sets it; OR and XOR clear it.
- R5: `flags[7]` (sign) equals bit 7 of the 8-bit result. The ninth (carry) bit never affects it.
- R6: `flags[6]` (zero) is 1 exactly when the 8-bit result is 8'h00.
- R7: `flags[2]` (parity) is 1 when the 8-bit result has an even number of ones, and 0 when the count is odd.
- R8: Bits 5 and 3 of `flags` always read 0, and bit 1 always reads 1, including after a load.
- R9: Compare (code 7) updates the flags as subtract does. `res_wr` is high only for `op_valid` with a code other than 7.
- R10: AND, OR and XOR clear the carry flag.
- R11: `flags` changes only on the clock edge following a cycle with `op_valid` or `flag_wr` high. Otherwise it holds its value.
- R12: With `flag_wr` high, the next edge copies bits 7, 6, 4, 2 and 0 of `flag_wdata` into `flags` and forces the fixed bits. `flag_wr` takes priority over `op_valid` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe; updates flags at the next edge |
| op_code | input | 3 | Operation select (see R2) |
| opnd_a | input | 8 | First operand (minuend for subtract) |
| opnd_b | input | 8 | Second operand |
| flag_wr | input | 1 | Load the whole status byte |
| flag_wdata | input | 8 | Value for the status load |
| result | output | 8 | Combinational 8-bit result |
| res_wr | output | 1 | Result is to be written back (not for compare) |
| flags | output | 8 | Registered status byte |

## Verification
The checker assumes that `op_code` is always a defined 3-bit value. It also assumes that `op_valid` and `flag_wr` never carry X once reset is released. Its flag properties compare the stored byte against the `result` of the previous cycle, so they rely on the operands staying steady across the strobe edge. The bench respects all of this: it changes inputs only on falling edges, drives the strobes as clean 0 or 1, and sets the stored carry through the load port before each vector that depends on it.

// File: rtl/alu8_pkg.sv
// Package alu8_pkg: shared operation codes and status-byte layout.
// Assumes an 8-bit datapath; the flag bit positions are fixed by the layout.
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    localparam int FB_CY = 0;
    localparam int FB_P  = 2;
    localparam int FB_AC = 4;
    localparam int FB_Z  = 6;
    localparam int FB_S  = 7;

    // Bits held at constant values, and the constant they hold.
    localparam logic [DATA_W-1:0] FIX_MASK = 8'b0010_1010;
    localparam logic [DATA_W-1:0] FIX_VAL  = 8'b0000_0010;
endpackage

// File: rtl/alu8_arith.sv
// Module alu8_arith: adder/subtractor with a full-width carry and a half-width carry.
// Assumes WIDTH is even. When is_sub is high, the carries are borrows (1 = underflow).
module alu8_arith #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             is_sub,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             half
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH:0] full_sum;
    logic [HALF:0]  low_sum;

    // Purpose: extended-width sum or difference so the top bit is the carry or borrow.
    always_comb begin
        if (is_sub) begin
            full_sum = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin};
            low_sum  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
        end else begin
            full_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
            low_sum  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
        end
    end

    assign res  = full_sum[WIDTH-1:0];
    assign cout = full_sum[WIDTH];
    assign half = low_sum[HALF];
endmodule

// File: rtl/alu8_logic.sv
// Module alu8_logic: bitwise AND / OR / XOR selected by a 2-bit code.
// Assumes sel 0 = AND, 1 = OR, 2 = XOR. Code 3 is unused and returns zero.
module alu8_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] res
);
    // Purpose: pick the bitwise function.
    always_comb begin
        unique case (sel)
            2'd0:    res = a & b;
            2'd1:    res = a | b;
            2'd2:    res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Module alu8_flagreg: status byte storage with update and full-load paths.
// Assumes a synchronous active-low reset. A load wins over an update, and the
// fixed bits are forced on every write.
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [DATA_W-1:0] upd_val,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_val,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    // Purpose: choose the next value by priority (load, then update, then hold).
    always_comb begin
        if (ld_en)       nxt = ld_val;
        else if (upd_en) nxt = upd_val;
        else             nxt = q;
    end

    // Purpose: register the status byte with the fixed bits forced.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= FIX_VAL;
        else        q <= (nxt & ~FIX_MASK) | FIX_VAL;
    end
endmodule

// File: rtl/alu8_flags.sv
// Module alu8_flags: top of the 8-bit ALU with its registered status byte.
// Assumes op_code is always a defined value. The result is combinational;
// the flags update on the edge after op_valid or flag_wr.
module alu8_flags
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              flag_wr,
    input  logic [DATA_W-1:0] flag_wdata,
    output logic [DATA_W-1:0] result,
    output logic              res_wr,
    output logic [DATA_W-1:0] flags
);
    alu_op_e           op;
    logic              is_logic;
    logic              is_sub;
    logic              use_cin;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] logic_res;
    logic              arith_cy;
    logic              arith_ac;
    logic              cy_new;
    logic              ac_new;
    logic [DATA_W-1:0] flag_new;

    assign op       = alu_op_e'(op_code);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    assign use_cin  = (op == OP_ADC) || (op == OP_SBB);

    alu8_arith #(.WIDTH(DATA_W)) i_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .cin    (use_cin & flags[FB_CY]),
        .is_sub (is_sub),
        .res    (arith_res),
        .cout   (arith_cy),
        .half   (arith_ac)
    );

    alu8_logic #(.WIDTH(DATA_W)) i_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (op_code[1:0]),
        .res (logic_res)
    );

    // Purpose: select the result and the carry-type flags for the operation class.
    always_comb begin
        if (is_logic) begin
            result = logic_res;
            cy_new = 1'b0;
            ac_new = (op == OP_AND);
        end else begin
            result = arith_res;
            cy_new = arith_cy;
            ac_new = arith_ac;
        end
    end

    // Purpose: assemble the candidate status byte from the result.
    always_comb begin
        flag_new        = FIX_VAL;
        flag_new[FB_CY] = cy_new;
        flag_new[FB_AC] = ac_new;
        flag_new[FB_P]  = ~^result;
        flag_new[FB_Z]  = (result == '0);
        flag_new[FB_S]  = result[DATA_W-1];
    end

    assign res_wr = op_valid && (op != OP_CMP);

    alu8_flagreg i_flagreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid),
        .upd_val (flag_new),
        .ld_en   (flag_wr),
        .ld_val  (flag_wdata),
        .q       (flags)
    );
endmodule

// File: rtl/alu8_flags_chk.sv
// Module alu8_flags_chk: timing properties of the ALU status byte, bound to alu8_flags.
// Assumes op_code is defined and the strobes are never X after reset.
module alu8_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic       flag_wr,
    input logic [7:0] flag_wdata,
    input logic [7:0] result,
    input logic       res_wr,
    input logic [7:0] flags
);
    logic op_upd;
    assign op_upd = op_valid && !flag_wr;

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b1)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !flag_wr) |=> $stable(flags)); // R11
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> ({flags[7:6], flags[4], flags[2], flags[0]} ==
                     {$past(flag_wdata[7:6]), $past(flag_wdata[4]), $past(flag_wdata[2]), $past(flag_wdata[0])})); // R12
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd7) |-> !res_wr); // R9
    AST_SIGN_BIT7: assert property (@(posedge clk) disable iff (!rst_n)
        op_upd |=> (flags[7] == $past(result[7]))); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_upd |=> (flags[6] == ($past(result) == 8'h00))); // R6
    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        op_upd |=> (flags[2] == ($countones($past(result)) % 2 == 0))); // R7
    AST_LOGIC_CY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_upd && op_code inside {3'd4, 3'd5, 3'd6}) |=> !flags[0]); // R10
    AST_AND_AC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_upd && op_code == 3'd4) |=> flags[4]); // R4
endmodule

bind alu8_flags alu8_flags_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .result     (result),
    .res_wr     (res_wr),
    .flags      (flags)
);

// File: tb/test_alu8_flags.sv
// Bench test_alu8_flags: a vector table walked by one loop, then directed
// tests for reset, hold, load and priority.
module test_alu8_flags;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // Vector layout: {op[3], a[8], b[8], carry_in[1], result[8], flags[8]}
    localparam logic [35:0] VEC [NVEC] = '{
        {3'd0, 8'h45, 8'hF3, 1'b0, 8'h38, 8'h03},  // R2 R3 add carry out
        {3'd0, 8'h85, 8'h1E, 1'b0, 8'hA3, 8'h96},  // R4 R5 R7 half carry, sign, even parity
        {3'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h57},  // R2 adc uses carry, R6 zero
        {3'd0, 8'h00, 8'h00, 1'b1, 8'h00, 8'h46},  // R2 add ignores stored carry
        {3'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h16},  // R4 half borrow
        {3'd2, 8'h01, 8'h02, 1'b0, 8'hFF, 8'h97},  // R3 borrow
        {3'd3, 8'h05, 8'h05, 1'b1, 8'hFF, 8'h97},  // R3 sbb with borrow in
        {3'd3, 8'h05, 8'h04, 1'b1, 8'h00, 8'h46},  // R3 sbb exact zero
        {3'd4, 8'hF0, 8'h3C, 1'b0, 8'h30, 8'h16},  // R4 and sets AC
        {3'd4, 8'h0F, 8'hF0, 1'b1, 8'h00, 8'h56},  // R10 and clears carry
        {3'd5, 8'h80, 8'h01, 1'b1, 8'h81, 8'h86},  // R10 or
        {3'd6, 8'h55, 8'hAA, 1'b0, 8'hFF, 8'h86},  // R2 xor
        {3'd6, 8'h5A, 8'h5A, 1'b1, 8'h00, 8'h46},  // R10 xor zero
        {3'd7, 8'h20, 8'h30, 1'b0, 8'hF0, 8'h87},  // R9 compare borrow
        {3'd7, 8'h42, 8'h42, 1'b0, 8'h00, 8'h46},  // R9 compare equal
        {3'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h92},  // R5 sign from bit 7, odd parity
        {3'd0, 8'h80, 8'h80, 1'b0, 8'h00, 8'h47}   // R5 sign ignores ninth bit
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [2:0] op_code;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic       flag_wr;
    logic [7:0] flag_wdata;
    logic [7:0] result;
    logic       res_wr;
    logic [7:0] flags;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu8_flags i_alu8_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .result     (result),
        .res_wr     (res_wr),
        .flags      (flags)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_flags(input logic [7:0] val);
        @(negedge clk);
        flag_wr    = 1'b1;
        flag_wdata = val;
        @(negedge clk);
        flag_wr    = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; opnd_a = '0; opnd_b = '0;
        flag_wr = 1'b0; flag_wdata = '0;
        repeat (3) @(negedge clk);
        check("R1 reset flags", flags, 8'h02);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            load_flags({7'd0, VEC[i][16]});
            op_code  = VEC[i][35:33];
            opnd_a   = VEC[i][32:25];
            opnd_b   = VEC[i][24:17];
            op_valid = 1'b1;
            #1;
            check("R2 result", result, VEC[i][15:8]);
            check("R9 res_wr", {7'd0, res_wr}, {7'd0, VEC[i][35:33] != 3'd7});
            @(negedge clk);
            op_valid = 1'b0;
            check("R3-R7 flags", flags, VEC[i][7:0]);
        end

        // R11: no strobe keeps the flags unchanged even with new operands.
        opnd_a = 8'h00; opnd_b = 8'h00; op_code = 3'd6;
        repeat (3) @(negedge clk);
        check("R11 hold", flags, 8'h47);

        // R12 and R8: full load forces the fixed bits.
        load_flags(8'hFF);
        check("R12 R8 load ones", flags, 8'hD7);
        load_flags(8'h00);
        check("R12 R8 load zeros", flags, 8'h02);

        // R12: load wins over a simultaneous operation.
        @(negedge clk);
        op_code = 3'd0; opnd_a = 8'h45; opnd_b = 8'hF3;
        op_valid = 1'b1; flag_wr = 1'b1; flag_wdata = 8'h10;
        @(negedge clk);
        op_valid = 1'b0; flag_wr = 1'b0;
        check("R12 load priority", flags, 8'h12);

        // R1: reset mid-run returns the flags to the reset value.
        load_flags(8'hC5);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", flags, 8'h02);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule